// File: doc/BRIEF.md
# Burst Address Generator

This block produces the address presented to a synchronous burst memory. A new start address is captured whenever one of two active-low address strobes is low at a clock edge. One strobe belongs to the processor side and only counts while the active-low chip enable is low; the other belongs to the controller side and is always honoured. After a load the block walks a four-beat burst on the two lowest address bits while the upper bits stay fixed.

The beat order is chosen per burst by an order-select input: low gives a linear order (start plus the beat count, modulo four), high gives an interleaved order (start XOR the beat count). An active-low advance input moves to the next beat; holding it high parks the burst on its current address. After the fourth beat the pattern wraps back to the start and repeats. A new address may be loaded on any cycle, so bursting is optional.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets addr_out to zero and burst_start to 0 in the following cycle.
- R2: When strobe_ctl_n is low at a clock edge, addr_out equals the start_addr sampled at that edge from the next cycle on, and burst_start is 1 in that next cycle only (0 in cycles that follow an edge with no load).
- R3: With order_ilv low at the load, each advance (advance_n low, no load) moves addr_out[1:0] to the start low bits plus the beat count, modulo 4 (start 10 gives 10, 11, 00, 01).
- R4: With order_ilv high at the load, beat k presents the start low bits XOR k (start 10 gives 10, 11, 00, 01; start 11 gives 11, 10, 01, 00).
- R5: After the fourth beat a further advance returns addr_out to the start address and the four-beat pattern repeats.
- R6: While advance_n is high and no load occurs, addr_out holds its value.
- R7: A load restarts the beat count at zero whatever the level of advance_n.
- R8: strobe_cpu_n low has no effect while chip_en_n is high; with chip_en_n low it loads exactly as strobe_ctl_n does. strobe_ctl_n is never masked by chip_en_n.
- R9: Loads on consecutive cycles each take effect, with no idle cycle between them.
- R10: order_ilv is sampled only at a load; changing it in mid-burst does not change the order of that burst.
- R11: addr_out bits above bit 1 stay equal to the loaded start address for the whole burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_addr | input | ADDR_W | External start address |
| strobe_cpu_n | input | 1 | Processor-side load strobe, active low, gated by chip_en_n |
| strobe_ctl_n | input | 1 | Controller-side load strobe, active low, ungated |
| chip_en_n | input | 1 | Chip enable for the processor strobe, active low |
| advance_n | input | 1 | Step to next beat, active low; high suspends |
| order_ilv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| addr_out | output | ADDR_W | Current burst address |
| burst_start | output | 1 | High in the first cycle of a freshly loaded burst |

## Verification
Bursts are run from every low-bit start value in both orders, which separates an adder from an XOR stepper (starts 01 and 11 differ between the two) and exposes a wrap that fails to return to the start. Suspends inside a burst and loads with advance low show whether the count holds and restarts correctly. The processor strobe is driven with the chip enable both high and low, while the controller strobe is driven with the enable high, to tell the gated path from the ungated one; flipping the order input in mid-burst shows whether it was latched at the load.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              strobe_cpu_n,
  input  logic              strobe_ctl_n,
  input  logic              chip_en_n,
  input  logic              advance_n,
  input  logic              order_ilv,
  output logic [ADDR_W-1:0] addr_out,
  output logic              burst_start
);

  localparam int HI_W = ADDR_W - 2;

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        beat_q;
  logic              ilv_q;
  logic              start_q;
  logic [1:0]        low_bits;
  logic              load;

  assign load = (!strobe_cpu_n && !chip_en_n) || !strobe_ctl_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      beat_q  <= '0;
      ilv_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= load;
      if (load) begin
        base_q <= start_addr;
        beat_q <= '0;
        ilv_q  <= order_ilv;
      end else if (!advance_n) begin
        beat_q <= beat_q + 2'd1;
      end
    end
  end

  assign low_bits    = ilv_q ? (base_q[1:0] ^ beat_q) : (base_q[1:0] + beat_q);
  assign addr_out    = {base_q[ADDR_W-1:2], low_bits};
  assign burst_start = start_q;

  assert_load_captures_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (addr_out == $past(start_addr)) && burst_start);

  assert_suspend_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (!load && advance_n) |=> $stable(addr_out));

  assert_upper_fixed_R11: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(addr_out[ADDR_W-1:2]));

  assert_linear_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!load && !advance_n && !ilv_q) |=> addr_out[1:0] == $past(addr_out[1:0]) + 2'd1);

  assert_no_start_flag_R2: assert property (@(posedge clk) disable iff (rst)
    !load |=> !burst_start);

  assert_upper_width_R11: assert final (HI_W >= 1);

endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int W = 20;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] start_addr;
  logic         strobe_cpu_n, strobe_ctl_n, chip_en_n, advance_n, order_ilv;
  logic [W-1:0] addr_out;
  logic         burst_start;

  integer checks = 0;
  integer errors = 0;
  logic [W-1:0] m_base;
  integer       m_beat;
  logic         m_ilv;
  logic         m_start;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(W)) uut (
    .clk(clk), .rst(rst), .start_addr(start_addr),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
    .chip_en_n(chip_en_n), .advance_n(advance_n), .order_ilv(order_ilv),
    .addr_out(addr_out), .burst_start(burst_start)
  );

  function automatic logic [W-1:0] model_addr();
    integer b;
    integer lo;
    b  = m_base[1:0];
    lo = m_ilv ? (b ^ m_beat) : ((b + m_beat) % 4);
    return {m_base[W-1:2], lo[1:0]};
  endfunction

  task automatic cyc(input string tag, input logic r, input logic [W-1:0] a,
                     input logic cpu_n, input logic ctl_n, input logic ce_n,
                     input logic adv_n, input logic ilv);
    logic ld;
    rst = r; start_addr = a; strobe_cpu_n = cpu_n; strobe_ctl_n = ctl_n;
    chip_en_n = ce_n; advance_n = adv_n; order_ilv = ilv;
    @(posedge clk);
    ld = (!cpu_n && !ce_n) || !ctl_n;
    if (r) begin
      m_base = '0; m_beat = 0; m_ilv = 1'b0; m_start = 1'b0;
    end else begin
      m_start = ld;
      if (ld) begin
        m_base = a; m_beat = 0; m_ilv = ilv;
      end else if (!adv_n) begin
        m_beat = (m_beat + 1) % 4;
      end
    end
    @(negedge clk);
    checks = checks + 1;
    if (addr_out !== model_addr() || burst_start !== m_start) begin
      errors = errors + 1;
      $display("FAIL %s: addr=%h start=%b expected addr=%h start=%b",
               tag, addr_out, burst_start, model_addr(), m_start);
    end
  endtask

  initial begin
    #1_000_000;
    errors = errors + 1;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    m_base = '0; m_beat = 0; m_ilv = 1'b0; m_start = 1'b0;
    @(negedge clk);
    cyc("R1", 1, 20'h0, 1, 1, 1, 1, 0);
    cyc("R1", 1, 20'h0, 1, 1, 1, 1, 0);
    for (int s = 0; s < 4; s++) begin
      for (int m = 0; m < 2; m++) begin
        cyc("R2", 0, 20'hABC40 | s, 1, 0, 1, 0, m[0]);
        for (int k = 0; k < 3; k++)
          cyc(m ? "R4" : "R3", 0, 20'h0, 1, 1, 1, 0, m[0]);
        cyc("R5", 0, 20'h0, 1, 1, 1, 0, m[0]);
        cyc("R11", 0, 20'hFFFFF, 1, 1, 1, 0, m[0]);
      end
    end
    cyc("R2", 0, 20'h12342, 1, 0, 1, 0, 1);
    cyc("R4", 0, 20'h0, 1, 1, 1, 0, 1);
    cyc("R6", 0, 20'h0, 1, 1, 1, 1, 1);
    cyc("R6", 0, 20'h0, 1, 1, 1, 1, 0);
    cyc("R10", 0, 20'h0, 1, 1, 1, 0, 0);
    cyc("R10", 0, 20'h0, 1, 1, 1, 0, 0);
    cyc("R8", 0, 20'h55551, 0, 1, 1, 0, 0);
    cyc("R8", 0, 20'h55551, 0, 1, 1, 1, 0);
    cyc("R8", 0, 20'h66663, 0, 1, 0, 1, 0);
    cyc("R3", 0, 20'h0, 1, 1, 0, 0, 1);
    cyc("R8", 0, 20'h77772, 1, 0, 1, 1, 0);
    cyc("R7", 0, 20'h0, 1, 1, 1, 0, 0);
    cyc("R7", 0, 20'h0, 1, 1, 1, 0, 0);
    cyc("R7", 0, 20'h11113, 1, 0, 1, 0, 0);
    cyc("R7", 0, 20'h22221, 0, 1, 0, 0, 1);
    for (int i = 0; i < 6; i++)
      cyc("R9", 0, 20'h30000 + i * 20'h1235, i[0], ~i[0], 0, i[1], i[0]);
    cyc("R3", 0, 20'h0, 1, 1, 1, 0, 0);
    cyc("R1", 1, 20'h0, 1, 1, 1, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule